// File: doc/BRIEF.md
# Serial Path-Overhead Insertion Port

This block is one channel's serial input port for path-overhead bytes headed to an outgoing SONET/SDH frame generator. It runs on a slow overhead clock of 576 kHz with a 8 kHz frame pulse, so each overhead frame has 72 bit periods. Those bits are nine bytes, sent MSB first. Slot 0 starts at the bit that the frame pulse marks. The block turns the serial data into bytes and hands each completed byte to the framer's overhead multiplexer. Each byte comes with its slot index and an insert flag. A byte is marked for insertion only when the per-byte enable pin is high during its MSB.

A mode input sets the timing direction. In contradirectional mode (`cfg_mode` = 0) the block divides its system clock by `CLK_DIV` and drives the overhead clock and the frame pulse itself. In codirectional mode (`cfg_mode` = 1) both come in from outside. In that mode the data path is switched off and only the frame alignment is tracked. A second input, `cfg_ins_en`, can mask the enable pin for every byte.

The byte output is a valid/ready stream. Once `out_valid` rises, data, slot and flag stay fixed until the cycle in which `out_ready` is sampled high. The byte rate is one per eight overhead bits, so the consumer has that long to respond. If a new byte completes while the old one is still waiting, the new byte replaces it and `out_valid` stays high. The stale byte is lost. If a completion falls in the same cycle as a handshake, the new byte is presented.

Top module: `ohins_port`

## Requirements
- R1: With `cfg_mode`=0, `oh_clk_oe` and `oh_fp_oe` are 1 and `oh_clk_o` has a period of `CLK_DIV` system clocks. It is low for the first `CLK_DIV/2` clocks of each period and high for the rest. Inputs are sampled in the first clock of the high phase.
- R2: With `cfg_mode`=0, `oh_fp_o` rises together with a falling edge of `oh_clk_o`. It stays high for exactly one overhead bit period and recurs every 72 bit periods.
- R3: Frame bit k (k=0 at the frame pulse) goes to slot k/8, at byte bit 7-(k mod 8), so the MSB comes first. Each completed byte appears on `out_data` with `out_slot` = k/8 (0..8).
- R4: `out_insert` of a byte equals the `oh_ins_i` level sampled at that byte's MSB, ANDed with `cfg_ins_en`. The enable level on the other seven bits has no effect.
- R5: While `cfg_ins_en` is 0, every byte is delivered with `out_insert` = 0.
- R6: With `cfg_mode`=1, `out_valid` stays 0 whatever `oh_data_i` and `oh_ins_i` do. `oh_clk_oe`, `oh_fp_oe`, `oh_clk_o` and `oh_fp_o` are 0.
- R7: `out_valid` stays high with stable data, slot and flag until `out_ready` is sampled high, and then drops. A byte that completes while one is pending replaces it.
- R8: With `cfg_mode`=1, the bit position follows `oh_fp_i` sampled on rising `oh_clk_i`. A pulse on any bit other than the expected bit 0 resynchronises the counter and raises `oh_misalign` for one system clock. An aligned pulse raises nothing.
- R9: While `rst` is high, `out_valid`, `oh_misalign` and `oh_clk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 0 = block drives overhead timing, 1 = timing received |
| cfg_ins_en | input | 1 | 0 masks the per-byte insertion enable |
| oh_clk_i | input | 1 | Overhead clock input (mode 1) |
| oh_fp_i | input | 1 | Frame pulse input (mode 1) |
| oh_clk_o | output | 1 | Generated overhead clock (mode 0) |
| oh_clk_oe | output | 1 | Output enable for `oh_clk_o` |
| oh_fp_o | output | 1 | Generated frame pulse (mode 0) |
| oh_fp_oe | output | 1 | Output enable for `oh_fp_o` |
| oh_data_i | input | 1 | Serial overhead data, MSB first |
| oh_ins_i | input | 1 | Per-byte insertion enable, sampled at MSB |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | BYTE_W | Assembled byte |
| out_slot | output | SLOT_W | Byte slot index 0..SLOTS-1 |
| out_insert | output | 1 | Byte is to be inserted |
| oh_misalign | output | 1 | One-cycle flag on a resynchronising frame pulse |

## Verification
The byte path is swept over every 8-bit value across slots. The enable is raised on the MSB of one rotating slot, and noise is put on the non-MSB bits of other slots. This separates a wrong bit order or slot count from an enable sampled on the wrong bit. A frame with the enable held high and the mask cleared shows whether the mask is applied. A frame with the consumer stalled tells a holding output apart from one that overwrites or drops. In codirectional mode, aligned pulses followed by one early pulse show that a resynchronisation flags once and that the realigned period after it stays quiet.

// File: rtl/ohins_pkg.sv
package ohins_pkg;
  typedef enum logic {
    MODE_CONTRA = 1'b0,
    MODE_CODIR  = 1'b1
  } oh_mode_e;
endpackage

// File: rtl/ohins_timing.sv
module ohins_timing #(
  parameter int CLK_DIV     = 434,
  parameter int FRAME_BITS  = 72,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_codir,
  input  logic oh_clk_i,
  input  logic oh_fp_i,
  output logic oh_clk_o,
  output logic oh_fp_o,
  output logic timing_oe,
  output logic bit_stb,
  output logic fp_smp
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;
  localparam int POS_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0]       div_cnt;
  logic [POS_W-1:0]       gen_pos;
  logic [SYNC_STAGES-1:0] ck_sync, fp_sync;
  logic                   ck_last;
  logic                   contra_rise, codir_rise;

  // divider and generated bit position, advanced at the falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      gen_pos <= '0;
    end else if (!mode_codir) begin
      if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
        div_cnt <= '0;
        gen_pos <= (gen_pos == POS_W'(FRAME_BITS - 1)) ? '0 : gen_pos + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // synchroniser chain for received timing
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          ck_sync[g] <= 1'b0;
          fp_sync[g] <= 1'b0;
        end else begin
          ck_sync[g] <= oh_clk_i;
          fp_sync[g] <= oh_fp_i;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) begin
          ck_sync[g] <= 1'b0;
          fp_sync[g] <= 1'b0;
        end else begin
          ck_sync[g] <= ck_sync[g-1];
          fp_sync[g] <= fp_sync[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ck_last <= 1'b0;
    else     ck_last <= ck_sync[SYNC_STAGES-1];
  end

  assign contra_rise = !mode_codir && (div_cnt == DIV_W'(HALF));
  assign codir_rise  = mode_codir && ck_sync[SYNC_STAGES-1] && !ck_last;
  assign bit_stb     = contra_rise || codir_rise;
  assign fp_smp      = mode_codir ? fp_sync[SYNC_STAGES-1] : (gen_pos == '0);

  assign oh_clk_o  = !mode_codir && (div_cnt >= DIV_W'(HALF));
  assign oh_fp_o   = !mode_codir && (gen_pos == '0);
  assign timing_oe = !mode_codir;

  // R2
  fp_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_codir && $past(!mode_codir) && $rose(oh_fp_o)) |-> $fell(oh_clk_o));
endmodule

// File: rtl/ohins_bitcnt.sv
module ohins_bitcnt #(
  parameter int FRAME_BITS = 72,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_codir,
  input  logic             bit_stb,
  input  logic             fp_smp,
  output logic [POS_W-1:0] cur_pos,
  output logic             misalign
);
  logic [POS_W-1:0] samp_pos, exp_pos;

  assign exp_pos = (samp_pos == POS_W'(FRAME_BITS - 1)) ? '0 : samp_pos + 1'b1;
  assign cur_pos = fp_smp ? '0 : exp_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_pos <= POS_W'(FRAME_BITS - 1);
      misalign <= 1'b0;
    end else begin
      misalign <= bit_stb && fp_smp && (exp_pos != '0);
      if (bit_stb) samp_pos <= cur_pos;
    end
  end

  // R8
  mis_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |=> !misalign);
  // R8
  contra_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_codir && $past(!mode_codir)) |-> !misalign);
endmodule

// File: rtl/ohins_deser.sv
module ohins_deser #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 9,
  localparam int POS_W  = $clog2(BYTE_W * SLOTS),
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_codir,
  input  logic              ins_gate,
  input  logic              bit_stb,
  input  logic [POS_W-1:0]  cur_pos,
  input  logic              data_i,
  input  logic              ins_i,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic [SLOT_W-1:0] out_slot,
  output logic              out_insert
);
  logic [BYTE_W-2:0] shreg;
  logic              ins_q;
  logic              take, at_msb, byte_done;

  assign take      = bit_stb && !mode_codir;
  assign at_msb    = (cur_pos[BIT_W-1:0] == '0);
  assign byte_done = take && (cur_pos[BIT_W-1:0] == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      ins_q <= 1'b0;
    end else if (take) begin
      shreg <= {shreg[BYTE_W-3:0], data_i};
      if (at_msb) ins_q <= ins_i && ins_gate;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_codir) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_slot   <= '0;
      out_insert <= 1'b0;
    end else if (byte_done) begin
      out_valid  <= 1'b1;
      out_data   <= {shreg, data_i};
      out_slot   <= SLOT_W'(cur_pos >> BIT_W);
      out_insert <= ins_q;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !byte_done && !mode_codir) |=>
      (out_valid && $stable(out_data) && $stable(out_slot) && $stable(out_insert)));
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot < SLOT_W'(SLOTS)));
  // R6
  codir_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_codir |=> !out_valid);
endmodule

// File: rtl/ohins_port.sv
module ohins_port
  import ohins_pkg::*;
#(
  parameter int CLK_DIV     = 434,
  parameter int BYTE_W      = 8,
  parameter int SLOTS       = 9,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic              cfg_ins_en,
  input  logic              oh_clk_i,
  input  logic              oh_fp_i,
  output logic              oh_clk_o,
  output logic              oh_clk_oe,
  output logic              oh_fp_o,
  output logic              oh_fp_oe,
  input  logic              oh_data_i,
  input  logic              oh_ins_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic [SLOT_W-1:0] out_slot,
  output logic              out_insert,
  output logic              oh_misalign
);
  localparam int FRAME_BITS = BYTE_W * SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);

  logic             mode_codir, timing_oe, bit_stb, fp_smp;
  logic [POS_W-1:0] cur_pos;

  assign mode_codir = (cfg_mode == MODE_CODIR);
  assign oh_clk_oe  = timing_oe;
  assign oh_fp_oe   = timing_oe;

  ohins_timing #(
    .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_timing (
    .clk(clk), .rst(rst), .mode_codir(mode_codir),
    .oh_clk_i(oh_clk_i), .oh_fp_i(oh_fp_i),
    .oh_clk_o(oh_clk_o), .oh_fp_o(oh_fp_o), .timing_oe(timing_oe),
    .bit_stb(bit_stb), .fp_smp(fp_smp)
  );

  ohins_bitcnt #(.FRAME_BITS(FRAME_BITS)) u_bitcnt (
    .clk(clk), .rst(rst), .mode_codir(mode_codir),
    .bit_stb(bit_stb), .fp_smp(fp_smp),
    .cur_pos(cur_pos), .misalign(oh_misalign)
  );

  ohins_deser #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_deser (
    .clk(clk), .rst(rst), .mode_codir(mode_codir), .ins_gate(cfg_ins_en),
    .bit_stb(bit_stb), .cur_pos(cur_pos),
    .data_i(oh_data_i), .ins_i(oh_ins_i), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot),
    .out_insert(out_insert)
  );

  // R1
  oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    oh_clk_oe |-> (oh_fp_oe && !cfg_mode));
endmodule

// File: tb/ohins_port_tb.sv
`timescale 1ns/1ps
module ohins_port_tb;
  localparam int DIV = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic mode = 1'b0, ins_gate = 1'b1;
  logic ck_i = 1'b0, fp_i = 1'b0, d_i = 1'b0, e_i = 1'b0, rdy = 1'b1;
  logic ck_o, ck_oe, fp_o, fp_oe, vld, ins, mis;
  logic [7:0] dat;
  logic [3:0] slt;

  int n_tests = 0, n_fail = 0;
  int k = 0, got_n = 0, vld_seen = 0, mis_cyc = 0;
  logic [7:0] pat_byte [9];
  logic       pat_en   [72];
  logic [7:0] got_d [16];
  logic [3:0] got_s [16];
  logic       got_i [16];
  bit done = 1'b0;

  always #2 clk = ~clk;

  ohins_port #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(mode), .cfg_ins_en(ins_gate),
    .oh_clk_i(ck_i), .oh_fp_i(fp_i), .oh_clk_o(ck_o), .oh_clk_oe(ck_oe),
    .oh_fp_o(fp_o), .oh_fp_oe(fp_oe), .oh_data_i(d_i), .oh_ins_i(e_i),
    .out_valid(vld), .out_ready(rdy), .out_data(dat), .out_slot(slt),
    .out_insert(ins), .oh_misalign(mis)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // serial driver for the generated-timing mode: new bit after each falling edge
  always @(negedge ck_o) begin
    #1;
    if (fp_o) k = 0; else k = (k + 1) % 72;
    d_i = pat_byte[k / 8][7 - (k % 8)];
    e_i = pat_en[k];
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (vld) vld_seen++;
      if (mis) mis_cyc++;
      if (vld && rdy && got_n < 16) begin
        got_d[got_n] = dat; got_s[got_n] = slt; got_i[got_n] = ins;
        got_n++;
      end
    end
  end

  task automatic run_frame();
    @(posedge fp_o);
    got_n = 0;
    wait (got_n >= 9);
  endtask

  task automatic check_frame(input bit gate);
    for (int s = 0; s < 9; s++) begin
      chk(got_d[s] == pat_byte[s], "R3", "byte data", got_d[s], pat_byte[s]);
      chk(got_s[s] == 4'(s), "R3", "slot index", got_s[s], s);
      chk(got_i[s] == (pat_en[s*8] & gate), gate ? "R4" : "R5",
          "insert flag", got_i[s], pat_en[s*8] & gate);
    end
  endtask

  task automatic codir_bits(input int first, input int last);
    for (int i = first; i < last; i++) begin
      @(negedge clk);
      ck_i = 1'b0;
      fp_i = ((i % 72 == 0) && (i < 150)) || (i == 174) || (i == 246);
      d_i = ~d_i; e_i = 1'b1;
      repeat (DIV/2) @(negedge clk);
      ck_i = 1'b1;
      repeat (DIV/2 - 1) @(negedge clk);
    end
  endtask

  initial begin
    longint t0, t1;
    for (int s = 0; s < 9; s++) pat_byte[s] = 8'h00;
    for (int b = 0; b < 72; b++) pat_en[b] = 1'b0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(vld == 1'b0, "R9", "valid in reset", vld, 0);
    chk(mis == 1'b0, "R9", "misalign in reset", mis, 0);
    chk(ck_o == 1'b0, "R9", "clock out in reset", ck_o, 0);
    rst = 1'b0;

    // R1 clock generation
    chk(ck_oe && fp_oe, "R1", "output enables", {ck_oe, fp_oe}, 3);
    @(negedge ck_o); t0 = $time; @(negedge ck_o); t1 = $time;
    chk((t1 - t0) == 4 * DIV, "R1", "clock period ns", int'(t1 - t0), 4 * DIV);
    @(posedge ck_o); t0 = $time; @(negedge ck_o); t1 = $time;
    chk((t1 - t0) == 4 * (DIV - DIV/2), "R1", "high phase ns", int'(t1 - t0), 4 * (DIV - DIV/2));

    // R2 frame pulse
    @(posedge fp_o); t0 = $time;
    chk(ck_o == 1'b0, "R2", "clock low at pulse start", ck_o, 0);
    @(negedge fp_o); t1 = $time;
    chk((t1 - t0) == 4 * DIV, "R2", "pulse width ns", int'(t1 - t0), 4 * DIV);
    @(posedge fp_o); t1 = $time;
    chk((t1 - t0) == 72 * 4 * DIV, "R2", "pulse spacing ns", int'(t1 - t0), 72 * 4 * DIV);

    // R3 R4: sweep all byte values, rotating MSB enable, noise on other bits
    for (int f = 0; f < 29; f++) begin
      for (int s = 0; s < 9; s++) pat_byte[s] = 8'((f * 9 + s) % 256);
      for (int b = 0; b < 72; b++)
        pat_en[b] = (b % 8 == 0) ? ((b / 8) == (f % 9)) : ((b / 8) % 2 == 1);
      run_frame();
      check_frame(1'b1);
    end

    // R5: enable held high, mask cleared
    ins_gate = 1'b0;
    for (int s = 0; s < 9; s++) pat_byte[s] = 8'(8'hA5 ^ 8'(s * 17));
    for (int b = 0; b < 72; b++) pat_en[b] = 1'b1;
    run_frame();
    check_frame(1'b0);
    ins_gate = 1'b1;

    // R7 back-pressure: stall for a whole frame, latest byte must be held
    for (int s = 0; s < 9; s++) pat_byte[s] = 8'(8'h30 + s);
    @(posedge fp_o);
    rdy = 1'b0; got_n = 0;
    @(posedge fp_o);
    chk(got_n == 0, "R7", "no handshake while stalled", got_n, 0);
    chk(vld == 1'b1 && slt == 4'd8, "R7", "held slot", {vld, slt}, 8'h18);
    chk(dat == pat_byte[8], "R7", "held data (overwritten)", dat, pat_byte[8]);
    @(posedge clk); #1 rdy = 1'b1;
    @(posedge clk); #1;
    chk(vld == 1'b0 && got_n == 1, "R7", "valid drops after accept", {vld, 4'(got_n)}, 1);

    // codirectional phase
    mode = 1'b1; rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vld_seen = 0; mis_cyc = 0;
    chk({ck_oe, fp_oe, ck_o, fp_o} == 4'b0, "R6", "timing outputs off",
        {ck_oe, fp_oe, ck_o, fp_o}, 0);
    codir_bits(0, 150);
    chk(mis_cyc == 0, "R8", "aligned pulses not flagged", mis_cyc, 0);
    codir_bits(150, 260);
    repeat (8) @(negedge clk);
    chk(mis_cyc == 1, "R8", "early pulse flagged one cycle", mis_cyc, 1);
    chk(vld_seen == 0, "R6", "no bytes in codirectional mode", vld_seen, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R1-chain run: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule